// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts processor activity for profiling. It holds one cycle counter and four event counters, each 32 bits wide. Each event counter picks its source from a wide vector of single-cycle event pulses by means of an 8-bit code. A register bus with address, write enable, write data and read data reaches every register. Software preloads a counter with the two's complement of a sampling period. When that counter wraps, a sticky overflow flag is raised, and the level interrupt asserts if that flag is enabled.

The cycle counter can be slowed so that it advances once every 64 clocks. Counter resets are requested by writing self-clearing command bits in the control register. Software clears overflow flags by writing ones to them. A wrap on one counter never disturbs a flag that is already set on another counter.

Register word addresses: 0 control, 1 event select, 2 overflow flags, 3 interrupt enable, 4 cycle counter, 5 to 8 event counters 0 to 3.

Top module: `perfmon_unit`

## Requirements
- R1: While control bit 0 (enable) is 0, neither the cycle counter nor any event counter advances.
- R2: Writing 1 to control bit 1 zeroes all event counters, and writing 1 to control bit 2 zeroes the cycle counter. Both bits act for a single cycle and read back as 0.
- R3: With control bit 3 set, the cycle counter increments once every 64 enabled clocks. With bit 3 clear, it increments every enabled clock. A cycle-counter reset also restarts the divide-by-64 phase.
- R4: The event select register holds four 8-bit codes, one per counter: counter 0 in bits 7:0, counter 1 in bits 15:8, counter 2 in bits 23:16 and counter 3 in bits 31:24. A counter increments in a cycle where the event input indexed by its code is 1. Code 0xFF never counts.
- R5: A counter that advances from 0xFFFFFFFF to 0 sets its overflow flag on that same edge. Flag bit 0 belongs to the cycle counter, and bits 1 to 4 belong to event counters 0 to 3.
- R6: Writing the flag register clears every flag whose write-data bit is 1 and leaves the other flags alone. If a flag is set and cleared in the same cycle, it ends up set.
- R7: The interrupt enable register uses the flag bit layout. The irq output is 1 exactly when some flag and its enable bit are both 1, and it follows the flag and enable registers with no added delay.
- R8: Every counter can be written directly. A write takes priority over a same-cycle increment, so a counter preloaded with 2^32 - N wraps after exactly N counted events.
- R9: A flag, once set, stays set until a write to the flag register clears it. This holds even when other counters overflow.
- R10: Reading the control register returns the enable in bit 0, the divide mode in bit 3, zeros in bits 2:1 and 23:4, and a fixed identification value (default 0xA5) in bits 31:24. Writes to bits 31:24 have no effect.
- R11: Read data is registered: it shows the register addressed in the previous cycle, as it was before that edge. After reset all registers are 0, except the event select, which is 0xFFFFFFFF, and the identification field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_in | input | 256 | Event pulses, indexed by event code |
| irq | output | 1 | Level interrupt, any enabled flag set |

## Verification
Counters and flags change on the edge that samples a write or an event. A value read back appears on bus_rdata one edge after its address is presented, and it shows the state before that edge. irq changes on the same edge as the flag or enable that causes it. The bench's reference model advances on every rising edge, and both outputs are compared at every falling edge. Each directed check reads at least one edge after the stimulus edge it depends on; a wrap, for example, is read one idle edge after the edge that produced it. Directed checks of the divide-by-64 mode count the exact number of edges to the 64th and 128th ticks.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int ADDR_W = 4;

  // register word addresses
  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] A_EVSEL    = 4'd1;
  localparam logic [ADDR_W-1:0] A_FLAGS    = 4'd2;
  localparam logic [ADDR_W-1:0] A_IRQEN    = 4'd3;
  localparam logic [ADDR_W-1:0] A_CYCLE    = 4'd4;
  localparam logic [ADDR_W-1:0] A_EVT_BASE = 4'd5;

  // control register bit positions
  localparam int C_EN    = 0;
  localparam int C_EVRST = 1;
  localparam int C_CYRST = 2;
  localparam int C_DIV   = 3;
  localparam int ID_W    = 8;
endpackage

// File: rtl/perfmon_prescaler.sv
module perfmon_prescaler #(
  parameter int PW = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic div_mode,
  input  logic clr,
  output logic tick
);
  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || clr)          phase_q <= '0;
    else if (en && div_mode) phase_q <= phase_q + 1'b1;
  end

  assign tick = en && (!div_mode || (&phase_q));
endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (clr)  cnt <= '0;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  assign wrap = inc && !load && !clr && (&cnt);
endmodule

// File: rtl/perfmon_flags.sv
module perfmon_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_in,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic         ie_we,
  input  logic [N-1:0] ie_val,
  output logic [N-1:0] flags,
  output logic [N-1:0] ie,
  output logic         irq
);
  logic [N-1:0] flags_d, ie_d;

  always_comb begin
    flags_d = (flags & ~(clr_we ? clr_mask : '0)) | set_in;
    ie_d    = ie_we ? ie_val : ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      ie    <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_d;
      ie    <= ie_d;
      irq   <= |(flags_d & ie_d);
    end
  end
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
  import perfmon_pkg::*;
#(
  parameter int         CNT_W   = 32,
  parameter int         NUM_EVT = 4,
  parameter int         CODE_W  = 8,
  parameter int         PRESC_W = 6,
  parameter logic [7:0] ID_VAL  = 8'hA5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_we,
  input  logic [CNT_W-1:0]         bus_wdata,
  output logic [CNT_W-1:0]         bus_rdata,
  input  logic [(1<<CODE_W)-1:0]   evt_in,
  output logic                     irq
);
  localparam int EVSEL_W = NUM_EVT * CODE_W;
  localparam int NFLAG   = NUM_EVT + 1;

  logic                              ctrl_en, ctrl_div;
  logic [EVSEL_W-1:0]                evsel_q;
  logic [NUM_EVT-1:0][CNT_W-1:0]     evt_cnt;
  logic [CNT_W-1:0]                  cyc_q;
  logic [NFLAG-1:0]                  set_vec, flags_q, ie_q;
  logic                              tick;
  logic                              wr_ctrl, ev_rst, cy_rst;
  logic [CNT_W-1:0]                  rd_mux;

  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign ev_rst  = wr_ctrl && bus_wdata[C_EVRST];
  assign cy_rst  = wr_ctrl && bus_wdata[C_CYRST];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en  <= 1'b0;
      ctrl_div <= 1'b0;
      evsel_q  <= '1;
    end else begin
      if (wr_ctrl) begin
        ctrl_en  <= bus_wdata[C_EN];
        ctrl_div <= bus_wdata[C_DIV];
      end
      if (bus_we && (bus_addr == A_EVSEL)) evsel_q <= bus_wdata[EVSEL_W-1:0];
    end
  end

  perfmon_prescaler #(.PW(PRESC_W)) u_presc (
    .clk(clk), .rst(rst), .en(ctrl_en), .div_mode(ctrl_div),
    .clr(cy_rst), .tick(tick)
  );

  perfmon_counter #(.W(CNT_W)) u_cyc (
    .clk(clk), .rst(rst),
    .load(bus_we && (bus_addr == A_CYCLE)), .load_val(bus_wdata),
    .clr(cy_rst), .inc(tick), .cnt(cyc_q), .wrap(set_vec[0])
  );

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    logic [CODE_W-1:0] code;
    logic              hit;
    assign code = evsel_q[g*CODE_W +: CODE_W];
    assign hit  = ctrl_en && (code != {CODE_W{1'b1}}) && evt_in[code];
    perfmon_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst),
      .load(bus_we && (bus_addr == ADDR_W'(int'(A_EVT_BASE) + g))),
      .load_val(bus_wdata), .clr(ev_rst), .inc(hit),
      .cnt(evt_cnt[g]), .wrap(set_vec[g+1])
    );
  end

  perfmon_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set_in(set_vec),
    .clr_we(bus_we && (bus_addr == A_FLAGS)), .clr_mask(bus_wdata[NFLAG-1:0]),
    .ie_we(bus_we && (bus_addr == A_IRQEN)), .ie_val(bus_wdata[NFLAG-1:0]),
    .flags(flags_q), .ie(ie_q), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL: begin
        rd_mux[C_EN]             = ctrl_en;
        rd_mux[C_DIV]            = ctrl_div;
        rd_mux[CNT_W-1 -: ID_W]  = ID_VAL;
      end
      A_EVSEL: rd_mux = CNT_W'(evsel_q);
      A_FLAGS: rd_mux = CNT_W'(flags_q);
      A_IRQEN: rd_mux = CNT_W'(ie_q);
      A_CYCLE: rd_mux = cyc_q;
      default: begin
        for (int i = 0; i < NUM_EVT; i++)
          if (bus_addr == ADDR_W'(int'(A_EVT_BASE) + i)) rd_mux = evt_cnt[i];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/perfmon_checker.sv
module perfmon_checker
  import perfmon_pkg::*;
#(
  parameter int         CNT_W   = 32,
  parameter int         NUM_EVT = 4,
  parameter logic [7:0] ID_VAL  = 8'hA5
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_we,
  input logic [CNT_W-1:0]           bus_rdata,
  input logic                       irq,
  input logic                       ctrl_en,
  input logic                       ctrl_div,
  input logic [CNT_W-1:0]           cyc_q,
  input logic [NUM_EVT*CNT_W-1:0]   evt_cnt,
  input logic [NUM_EVT:0]           flags_q,
  input logic [NUM_EVT:0]           ie_q
);
  // R1: nothing advances while disabled and no bus write occurs
  assert_hold_when_off_R1: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !bus_we) |=> ($stable(cyc_q) && $stable(evt_cnt)));

  // R5: the cycle counter wrap sets flag bit 0 on the same edge
  assert_cycle_wrap_flag_R5: assert property (@(posedge clk) disable iff (rst)
    ((&cyc_q) && ctrl_en && !ctrl_div && !bus_we) |=> (cyc_q == '0 && flags_q[0]));

  // R9: flags stay set unless the flag register is written
  assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == A_FLAGS) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R7: the interrupt level matches enabled pending flags
  assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
    irq == (|(flags_q & ie_q)));

  // R10: control readback layout
  assert_ctrl_readback_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_CTRL) |=> (bus_rdata[2:1] == 2'b00 && bus_rdata[23:4] == '0 &&
                              bus_rdata[CNT_W-1 -: 8] == ID_VAL));
endmodule

bind perfmon_unit perfmon_checker #(
  .CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .ID_VAL(ID_VAL)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .irq(irq), .ctrl_en(ctrl_en), .ctrl_div(ctrl_div),
  .cyc_q(cyc_q), .evt_cnt(evt_cnt), .flags_q(flags_q), .ie_q(ie_q)
);

// File: tb/tb_perfmon_unit.sv
`timescale 1ns/1ps
module tb_perfmon_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [255:0] evt_in = '0;
  logic         irq;

  always #2.5 clk = ~clk;

  perfmon_unit dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq(irq)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string phase  = "R11";

  // behavioural reference model
  logic [31:0] m_cyc, m_evsel, m_rdata;
  logic [31:0] m_evt [4];
  logic [4:0]  m_flags, m_ie, m_set, m_clr;
  logic        m_en, m_div, m_irq, m_tick;
  int          m_phase;
  bit          m_started = 0;

  always @(posedge clk) begin
    m_started = 1;
    if (rst) begin
      m_cyc = 0; m_evsel = 32'hFFFF_FFFF; m_rdata = 0; m_flags = 0; m_ie = 0;
      m_en = 0; m_div = 0; m_irq = 0; m_phase = 0;
      foreach (m_evt[i]) m_evt[i] = 0;
    end else begin
      case (bus_addr)
        4'd0: m_rdata = {8'hA5, 20'h0, m_div, 2'b00, m_en};
        4'd1: m_rdata = m_evsel;
        4'd2: m_rdata = {27'h0, m_flags};
        4'd3: m_rdata = {27'h0, m_ie};
        4'd4: m_rdata = m_cyc;
        4'd5, 4'd6, 4'd7, 4'd8: m_rdata = m_evt[bus_addr - 5];
        default: m_rdata = 0;
      endcase
      m_set  = 0;
      m_tick = m_en && (!m_div || m_phase == 63);
      if (m_en && m_div) m_phase = (m_phase + 1) % 64;
      if (bus_we && bus_addr == 4) m_cyc = bus_wdata;
      else if (bus_we && bus_addr == 0 && bus_wdata[2]) begin m_cyc = 0; m_phase = 0; end
      else if (m_tick) begin
        if (m_cyc == 32'hFFFF_FFFF) m_set[0] = 1;
        m_cyc = m_cyc + 1;
      end
      for (int i = 0; i < 4; i++) begin
        int code;
        code = m_evsel[8*i +: 8];
        if (bus_we && bus_addr == 5 + i) m_evt[i] = bus_wdata;
        else if (bus_we && bus_addr == 0 && bus_wdata[1]) m_evt[i] = 0;
        else if (m_en && code != 255 && evt_in[code]) begin
          if (m_evt[i] == 32'hFFFF_FFFF) m_set[i+1] = 1;
          m_evt[i] = m_evt[i] + 1;
        end
      end
      if (bus_we && bus_addr == 0) begin m_en = bus_wdata[0]; m_div = bus_wdata[3]; end
      if (bus_we && bus_addr == 1) m_evsel = bus_wdata;
      if (bus_we && bus_addr == 3) m_ie = bus_wdata[4:0];
      m_clr   = (bus_we && bus_addr == 2) ? bus_wdata[4:0] : 5'h0;
      m_flags = (m_flags & ~m_clr) | m_set;
      m_irq   = |(m_flags & m_ie);
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (m_started && !done) begin
      chk(phase, "model rdata", bus_rdata, m_rdata);
      chk("R7", "model irq", {31'h0, irq}, {31'h0, m_irq});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    @(negedge clk);
    chk(req, "read", bus_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk("R11", "irq after reset", {31'h0, irq}, 32'h0);
    expect_rd(4'd1, 32'hFFFF_FFFF, "R11");
    expect_rd(4'd2, 32'h0, "R11");

    // R10: ID field ignores writes, reserved bits read zero
    phase = "R10";
    wr(4'd0, 32'hFFFF_FFF9);
    expect_rd(4'd0, 32'hA500_0009, "R10");

    // R1: disabled counters hold
    phase = "R1";
    wr(4'd0, 32'h0);
    wr(4'd4, 32'd100);
    wr(4'd1, 32'h0B07_0605);
    evt_in[5] = 1; evt_in[6] = 1; evt_in[7] = 1; evt_in[11] = 1;
    repeat (3) @(negedge clk);
    evt_in = '0;
    expect_rd(4'd4, 32'd100, "R1");
    expect_rd(4'd5, 32'd0, "R1");

    // R4: code selection and byte positions
    phase = "R4";
    wr(4'd0, 32'h1);
    evt_in[5] = 1; evt_in[7] = 1;
    @(negedge clk);
    evt_in = '0; evt_in[5] = 1; evt_in[11] = 1;
    @(negedge clk);
    evt_in = '0;
    expect_rd(4'd5, 32'd2, "R4");
    expect_rd(4'd6, 32'd0, "R4");
    expect_rd(4'd7, 32'd1, "R4");
    expect_rd(4'd8, 32'd1, "R4");
    wr(4'd1, 32'hFF07_0605);
    evt_in[11] = 1; evt_in[255] = 1;
    @(negedge clk);
    evt_in = '0;
    expect_rd(4'd8, 32'd1, "R4");

    // R2: self-clearing reset commands
    phase = "R2";
    wr(4'd0, 32'h3);
    expect_rd(4'd5, 32'd0, "R2");
    wr(4'd0, 32'h5);
    expect_rd(4'd4, 32'd0, "R2");
    expect_rd(4'd0, 32'hA500_0001, "R2");

    // R5: preload and wrap sets flag bit 1
    phase = "R5";
    wr(4'd5, 32'hFFFF_FFFE);
    evt_in[5] = 1;
    repeat (2) @(negedge clk);
    evt_in = '0;
    expect_rd(4'd2, 32'h2, "R5");
    expect_rd(4'd5, 32'h0, "R5");

    // R8: write beats a same-cycle increment
    phase = "R8";
    bus_addr = 4'd5; bus_we = 1; bus_wdata = 32'd7; evt_in[5] = 1;
    @(negedge clk);
    bus_we = 0; evt_in = '0;
    expect_rd(4'd5, 32'd7, "R8");

    // R7: enabling a pending flag raises irq
    phase = "R7";
    wr(4'd3, 32'h2);
    chk("R7", "irq after enable", {31'h0, irq}, 32'h1);

    // R6: write-one-to-clear, then set wins over clear
    phase = "R6";
    wr(4'd2, 32'h2);
    chk("R6", "irq after clear", {31'h0, irq}, 32'h0);
    expect_rd(4'd2, 32'h0, "R6");
    wr(4'd5, 32'hFFFF_FFFF);
    bus_addr = 4'd2; bus_we = 1; bus_wdata = 32'h2; evt_in[5] = 1;
    @(negedge clk);
    bus_we = 0; evt_in = '0;
    expect_rd(4'd2, 32'h2, "R6");
    chk("R6", "irq after set-wins", {31'h0, irq}, 32'h1);

    // R9: independent sticky flags
    phase = "R9";
    wr(4'd4, 32'hFFFF_FFFF);
    @(negedge clk);
    expect_rd(4'd2, 32'h3, "R9");
    wr(4'd2, 32'h1);
    expect_rd(4'd2, 32'h2, "R9");
    chk("R9", "irq kept", {31'h0, irq}, 32'h1);

    // R3: divide-by-64 cycle counting
    phase = "R3";
    wr(4'd0, 32'h5);
    wr(4'd0, 32'h9);
    repeat (130) @(negedge clk);
    expect_rd(4'd4, 32'd3, "R3");

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end
endmodule